// File: doc/BRIEF.md
# NCO Pixel Scanout Engine

This block turns a packed 4-bit-per-pixel framebuffer into a stream of palette indices for a 1024 x 600 raster refreshed at 72 Hz. It does not make sync pulses or porches. An external timing generator pulses `line_start` once per visible line. The engine then reads that line's bytes through a synchronous byte-read port and emits one 4-bit palette index each time its pixel-rate oscillator fires. Each index selects one entry of a 16-colour palette that lies outside the block.

The pixel rate comes from a 32-bit numerically controlled oscillator. On every system clock it adds an integer frequency word (the desired pixel frequency, scaled and rounded) to a phase accumulator. A pixel is due on each carry out of the top bit. The accumulator is forced to zero on every line start rather than left running. Any irregular spacing between pixels, which comes from the fraction that does not divide evenly, therefore falls at the same columns on every line, and the picture shows no line-to-line horizontal jitter.

The engine counts lines by itself: the first strobe after reset is line 0. Each line starts at byte address line x 512, because 1024 pixels at two per byte fill 512 bytes.

Top module: `nco_scanout`

## Requirements
- R1: While reset is held, `pix_valid`, `video_active` and `rd_en` are all low.
- R2: In the cycle after a clock edge that samples `line_start` high, `video_active` is high and `rd_en` is high with `rd_addr` equal to the current line number times 512 (line number in bits 18:9, bits 8:0 zero).
- R3: The phase step is the frequency word, limited to at most 0x8000_0000. Counting clock edges n = 1, 2, ... after the strobe edge, a pixel is presented (`pix_valid` high for one cycle) in the cycle after edge n exactly when floor(n x step / 2^32) differs from floor((n-1) x step / 2^32).
- R4: The phase accumulator reads zero after every line start, so pixel positions are identical on every line, including a line restarted by a strobe that arrives mid-line.
- R5: `rd_data` is taken one cycle after `rd_en`. Pixel 2j of a line is bits 3:0 of the byte at line base + j, and pixel 2j+1 is bits 7:4 of the same byte.
- R6: Exactly 1024 pixels are presented per line. `video_active` stays high through the last pixel and is low from the following cycle.
- R7: A full line issues exactly 511 reads after the opening one. Once a line has ended, no pixel and no read appear until the next `line_start`.
- R8: The line number advances by one per strobe and returns from 599 to 0.
- R9: With a frequency word of zero, a started line presents no pixels and `video_active` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| freq_word | input | 32 | Oscillator phase step per clock |
| line_start | input | 1 | One-cycle strobe opening a visible line |
| rd_en | output | 1 | Framebuffer byte read request |
| rd_addr | output | 19 | Framebuffer byte address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| pix_index | output | 4 | Palette index of the current pixel |
| pix_valid | output | 1 | Pixel presented this cycle |
| video_active | output | 1 | Line in progress |

## Verification
The bench runs the same fractional frequency word on two consecutive lines and on a line restarted mid-way. It compares every pixel's cycle with the carry formula. A free-running accumulator would shift those cycles on the later lines. A step above one half checks that the limit holds the rate at every other cycle rather than letting pixels run back to back. An exact half-rate line checks that the first pixel arrives just as the first byte lands, and that the low nibble is emitted before the high one. A bypass or nibble-order error would show up there as wrong indices. The line number is wrapped through 599, a zero step is checked to leave the line open with no output, and the quiet period after line end catches an extra pixel, a stray read or an active flag that stays high.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

    // Line-level state of the scanout engine.
    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,   // waiting for a line strobe
        SCAN_RUN   = 2'd1,   // emitting pixels of the current line
        SCAN_DRAIN = 2'd2    // last pixel on the output, line closing
    } scan_state_e;

endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [ACC_W-1:0] freq_word,
    output logic             tick,
    output logic [ACC_W-1:0] phase
);
    // Steps above one half of the phase circle are limited so that two
    // carries can never occur on adjacent clocks.
    localparam logic [ACC_W-1:0] HALF_STEP = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        step  = (freq_word > HALF_STEP) ? HALF_STEP : freq_word;
        sum   = {1'b0, acc_q} + {1'b0, step};
        acc_d = acc_q;
        tick  = 1'b0;
        if (clear) begin
            acc_d = '0;
        end else if (run) begin
            acc_d = sum[ACC_W-1:0];
            tick  = sum[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign phase = acc_q;

endmodule

// File: rtl/line_addr.sv
module line_addr #(
    parameter int LINE_CNT  = 600,
    parameter int ROW_SHIFT = 9,
    parameter int ADDR_W    = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] row_base
);
    localparam int LINE_W = $clog2(LINE_CNT);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINE_CNT - 1);

    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (advance) begin
            line_d = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
        end
        // A power-of-two row pitch turns the row multiply into a shift.
        row_base = ADDR_W'(line_q) << ROW_SHIFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

endmodule

// File: rtl/nco_scanout.sv
module nco_scanout
    import scanout_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int PIX_W    = 4,
    parameter int LINE_PIX = 1024,
    parameter int LINE_CNT = 600
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic [ACC_W-1:0]                                       freq_word,
    input  logic                                                   line_start,
    output logic                                                   rd_en,
    output logic [$clog2(LINE_CNT)+$clog2(LINE_PIX/2)-1:0]         rd_addr,
    input  logic [2*PIX_W-1:0]                                     rd_data,
    output logic [PIX_W-1:0]                                       pix_index,
    output logic                                                   pix_valid,
    output logic                                                   video_active
);
    localparam int BYTE_W    = 2 * PIX_W;
    localparam int ROW_SHIFT = $clog2(LINE_PIX / 2);
    localparam int ADDR_W    = $clog2(LINE_CNT) + ROW_SHIFT;
    localparam int CNT_W     = $clog2(LINE_PIX + 1);
    localparam logic [CNT_W-1:0] LAST_PIX = CNT_W'(LINE_PIX - 1);

    typedef struct packed {
        scan_state_e       st;
        logic [CNT_W-1:0]  cnt;     // pixels emitted in this line
        logic [BYTE_W-1:0] hold;    // byte of the pixel pair in progress
        logic              fresh;   // rd_data carries a new byte this cycle
        logic              rd_en;
        logic [ADDR_W-1:0] addr;
        logic [PIX_W-1:0]  pix;
        logic              pix_vld;
    } scan_t;

    scan_t s_d, s_q;

    logic              tick;
    logic [ACC_W-1:0]  phase;
    logic [ADDR_W-1:0] row_base;
    logic [BYTE_W-1:0] cur_byte;

    nco_phase #(
        .ACC_W (ACC_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (line_start),
        .run       (s_q.st == SCAN_RUN),
        .freq_word (freq_word),
        .tick      (tick),
        .phase     (phase)
    );

    line_addr #(
        .LINE_CNT  (LINE_CNT),
        .ROW_SHIFT (ROW_SHIFT),
        .ADDR_W    (ADDR_W)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (line_start),
        .row_base (row_base)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rd_en   = 1'b0;
        s_d.pix_vld = 1'b0;
        s_d.fresh   = s_q.rd_en;
        if (s_q.fresh) s_d.hold = rd_data;
        // A byte landing this cycle bypasses the holding register, so an
        // even pixel can leave on the same edge its byte arrives.
        cur_byte = s_q.fresh ? rd_data : s_q.hold;

        if (line_start) begin
            s_d.st    = SCAN_RUN;
            s_d.cnt   = '0;
            s_d.rd_en = 1'b1;
            s_d.addr  = row_base;
        end else begin
            case (s_q.st)
                SCAN_RUN: begin
                    if (tick) begin
                        s_d.pix_vld = 1'b1;
                        s_d.pix     = s_q.cnt[0] ? cur_byte[BYTE_W-1:PIX_W]
                                                 : cur_byte[PIX_W-1:0];
                        s_d.cnt     = s_q.cnt + 1'b1;
                        if (s_q.cnt == LAST_PIX) begin
                            s_d.st = SCAN_DRAIN;
                        end else if (s_q.cnt[0]) begin
                            // pair finished: fetch the next byte
                            s_d.rd_en = 1'b1;
                            s_d.addr  = s_q.addr + 1'b1;
                        end
                    end
                end
                SCAN_DRAIN: s_d.st = SCAN_IDLE;
                default:    s_d.st = SCAN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SCAN_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en        = s_q.rd_en;
    assign rd_addr      = s_q.addr;
    assign pix_index    = s_q.pix;
    assign pix_valid    = s_q.pix_vld;
    assign video_active = (s_q.st != SCAN_IDLE);

endmodule

// File: rtl/scanout_checker.sv
module scanout_checker #(
    parameter int ACC_W     = 32,
    parameter int ADDR_W    = 19,
    parameter int ROW_SHIFT = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              pix_valid,
    input logic              video_active,
    input logic [ACC_W-1:0]  phase
);

    AST_LINE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (video_active && rd_en && rd_addr[ROW_SHIFT-1:0] == '0)); // R2

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (phase == '0)); // R4

    AST_PIX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid); // R3

    AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> video_active); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!video_active && !line_start) |=> (!pix_valid && !rd_en)); // R7

endmodule

bind nco_scanout scanout_checker #(
    .ACC_W     (ACC_W),
    .ADDR_W    (ADDR_W),
    .ROW_SHIFT (ROW_SHIFT)
) i_scanout_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start   (line_start),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .pix_valid    (pix_valid),
    .video_active (video_active),
    .phase        (phase)
);

// File: tb/test_nco_scanout.sv
module test_nco_scanout;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] freq_word = '0;
    logic        line_start = 1'b0;
    logic        rd_en;
    logic [18:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic [3:0]  pix_index;
    logic        pix_valid;
    logic        video_active;

    int checks = 0;
    int fails  = 0;
    int exp_line = 0;
    int cur_base = 0;
    int emit_n [1024];
    int emit_ref [1024];

    always #10 clk = ~clk;

    nco_scanout i_nco_scanout (
        .clk          (clk),
        .rst_n        (rst_n),
        .freq_word    (freq_word),
        .line_start   (line_start),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .pix_index    (pix_index),
        .pix_valid    (pix_valid),
        .video_active (video_active)
    );

    function automatic logic [7:0] mem_byte(input int a);
        logic [18:0] ad;
        ad = 19'(a);
        return ad[7:0] ^ ad[16:9] ^ 8'h5A;
    endfunction

    // Synchronous framebuffer model: one cycle of read latency.
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem_byte(int'(rd_addr));
    end

    function automatic bit carry_at(input longint unsigned step, input int n);
        longint unsigned a, b;
        a = (longint'(n) * step) >> 32;
        b = (longint'(n - 1) * step) >> 32;
        return a != b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic strobe(output bit open_ok, output bit addr_ok, output int got_addr);
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        cur_base = exp_line * 512;
        open_ok  = (video_active === 1'b1) && (rd_en === 1'b1);
        addr_ok  = (rd_addr === 19'(cur_base));
        got_addr = int'(rd_addr);
        exp_line = (exp_line == 599) ? 0 : exp_line + 1;
    endtask

    task automatic strobe_checked();
        bit o, a;
        int ga;
        strobe(o, a, ga);
        check(o, "R2", "line open flags", o, 1);
        check(a, "R2", "line fetch address", ga, cur_base);
    endtask

    task automatic run_line(input logic [31:0] f, input int ncyc, input bit full);
        longint unsigned step;
        int  k, n_last, bad_t, bad_d, bad_a, reads;
        int  t_first, d_act, d_exp;
        bit  exp_v, exp_a;
        logic [7:0] eb;
        logic [3:0] en;
        step = (f > 32'h8000_0000) ? 64'h8000_0000 : {32'h0, f};
        k = 0; n_last = -1; bad_t = 0; bad_d = 0; bad_a = 0; reads = 0;
        t_first = 0; d_act = 0; d_exp = 0;
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            exp_v = (k < 1024) && carry_at(step, n);
            if (pix_valid !== exp_v) begin
                if (bad_t == 0) t_first = n;
                bad_t++;
            end
            if (exp_v) begin
                eb = mem_byte(cur_base + k / 2);
                en = (k % 2 == 1) ? eb[7:4] : eb[3:0];
                if (pix_index !== en) begin
                    if (bad_d == 0) begin d_act = int'(pix_index); d_exp = int'(en); end
                    bad_d++;
                end
                emit_n[k] = n;
                k++;
                if (k == 1024) n_last = n;
            end
            exp_a = !(n_last >= 0 && n > n_last);
            if (video_active !== exp_a) bad_a++;
            if (rd_en === 1'b1) reads++;
        end
        check(bad_t == 0, "R3", $sformatf("pixel timing errors (first at cycle %0d)", t_first), bad_t, 0);
        check(bad_d == 0, "R5", $sformatf("pixel value errors (first %0d vs %0d)", d_act, d_exp), bad_d, 0);
        check(bad_a == 0, "R6", "active flag errors", bad_a, 0);
        if (full) begin
            check(k == 1024, "R6", "pixels per line", k, 1024);
            check(reads == 511, "R7", "reads after opening fetch", reads, 511);
        end
    endtask

    task automatic quiet_window(input int ncyc);
        int bad;
        bad = 0;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (pix_valid !== 1'b0 || rd_en !== 1'b0 || video_active !== 1'b0) bad++;
        end
        check(bad == 0, "R7", "activity after line end", bad, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pix_valid === 1'b0, "R1", "pix_valid in reset", pix_valid, 0);
        check(video_active === 1'b0, "R1", "video_active in reset", video_active, 0);
        check(rd_en === 1'b0, "R1", "rd_en in reset", rd_en, 0);
        rst_n = 1'b1;
        quiet_window(4);
    endtask

    task automatic t_half_rate();
        freq_word = 32'h8000_0000;
        strobe_checked();
        run_line(freq_word, 2060, 1'b1);
        quiet_window(50);
    endtask

    task automatic t_fraction_repeat();
        int diff;
        freq_word = 32'h5555_5556;
        strobe_checked();
        run_line(freq_word, 3100, 1'b1);
        for (int i = 0; i < 1024; i++) emit_ref[i] = emit_n[i];
        strobe_checked();
        run_line(freq_word, 3100, 1'b1);
        diff = 0;
        for (int i = 0; i < 1024; i++) if (emit_n[i] != emit_ref[i]) diff++;
        check(diff == 0, "R4", "pixel columns differ between lines", diff, 0);
    endtask

    task automatic t_restart_mid();
        int diff;
        freq_word = 32'h5555_5556;
        strobe_checked();
        run_line(freq_word, 301, 1'b0);
        strobe_checked();
        run_line(freq_word, 3100, 1'b1);
        diff = 0;
        for (int i = 0; i < 1024; i++) if (emit_n[i] != emit_ref[i]) diff++;
        check(diff == 0, "R4", "pixel columns after mid-line restart", diff, 0);
    endtask

    task automatic t_clamp();
        freq_word = 32'hFFFF_FFFF;
        strobe_checked();
        run_line(freq_word, 2060, 1'b1);
    endtask

    task automatic t_zero_step();
        int bad;
        freq_word = 32'h0;
        strobe_checked();
        bad = 0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (pix_valid !== 1'b0 || video_active !== 1'b1) bad++;
        end
        check(bad == 0, "R9", "zero step output", bad, 0);
    endtask

    task automatic t_wrap();
        bit o, a;
        int ga, bad;
        freq_word = 32'h0100_0000;
        bad = 0;
        while (exp_line != 599) begin
            strobe(o, a, ga);
            if (!(o && a)) bad++;
        end
        check(bad == 0, "R8", "address sequence errors", bad, 0);
        strobe(o, a, ga);
        check(a, "R8", "last line address", ga, 599 * 512);
        strobe(o, a, ga);
        check(a && ga == 0, "R8", "wrapped line address", ga, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_half_rate();
        t_fraction_repeat();
        t_restart_mid();
        t_clamp();
        t_zero_step();
        t_wrap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule